// File: doc/BRIEF.md
# Edge-Interrupting Open-Drain Parallel I/O Port

This block is a parallel digital I/O port with 24 lines by default. Each line can serve as an input or as an output. Every line has an output latch and a separate input sampler. In the default open-drain mode, a 0 in the latch sinks the line to ground. A 1 in the latch releases the line, so an external source or a pull-up sets its level. Writing 1 to a bit therefore makes that line an input.

The sampled pad levels pass through a two-stage synchronizer and then go to a per-line edge detector. Two masks choose which transitions count: one for low-to-high and one for high-to-low. A transition that a mask enables latches a pending flag for that line. Software clears pending flags by writing 1 to them. All pending flags are ORed into one interrupt request, which a global enable bit gates.

A control bit switches the port to push-pull mode. In that mode all drivers start disabled after reset. A line's driver turns on the first time software writes that line's byte of the output register, and it stays on until reset.

Top module: `odio_port`

Register words, by byte address:

| Address | Contents |
|---|---|
| 0x00 | output latch |
| 0x04 | synchronized line levels (read-only) |
| 0x08 | rise-select mask |
| 0x0C | fall-select mask |
| 0x10 | pending flags (write 1 to clear) |
| 0x14 | control: bit 0 = interrupt enable, bit 1 = push-pull mode |

## Requirements
- R1: After reset, the register values are as follows. The output latch reads all ones (0xFFFFFF). Both masks, the pending flags and the control bits read zero. No line is driven (`line_oe` = 0) and `irq` is low.
- R2: In open-drain mode, a 0 in output latch bit i sets `line_oe[i]`=1 with `line_o[i]`=0. The line then reads 0 at address 0x04 even while the external source drives it high. A 1 releases the line (`line_oe[i]`=0).
- R3: A released line reads back its external level at address 0x04, after the synchronizer.
- R4: A line whose bit is set in only the rise mask flags rising edges only. A line set in only the fall mask flags falling edges only. A line set in both masks flags either edge. A line set in neither mask never flags. With rise mask 0b101 and fall mask 0b110, a falling step on lines 0..3 gives pending 0x6, and a rising step gives pending 0x5.
- R5: Writing 1 to a pending bit at 0x10 clears that bit. Writing 0 leaves the bit unchanged.
- R6: If an enabled edge arrives on a line in the same cycle as the clear write for that line, the pending flag stays set.
- R7: `irq` is high when control bit 0 is 1 and any pending bit is set. `irq` stays low while control bit 0 is 0, whatever the pending bits hold.
- R8: In push-pull mode (control bit 1 = 1), `line_oe[i]` is 0 until the output latch byte holding bit i has been written in push-pull mode. From then until reset, `line_oe[i]` is 1 and `line_o[i]` follows latch bit i.
- R9: Byte strobe k (`reg_wstrb[k]`) gates bits 8k+7..8k of a write. Bytes whose strobe is 0 keep their old value.
- R10: A write to the line-level word at 0x04 has no effect. The word keeps reporting the line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_addr | input | 5 | byte address of the register word |
| reg_we | input | 1 | write request, sampled at the clock edge |
| reg_wstrb | input | 4 | byte strobes of the write |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, registered one cycle after the address |
| line_in | input | 24 | levels sampled from the pads |
| line_oe | output | 24 | per-line driver enable |
| line_o | output | 24 | per-line driven value |
| irq | output | 1 | registered interrupt request |

## Verification
The assertions assume two things about the inputs. First, `reg_addr` selects one of the six register words. Second, reset is held for at least two cycles, so the sticky driver enables and the synchronizer stages hold their reset values before the first comparison. The bench changes the external line levels only between clock edges and holds each level for several cycles. This makes every step produce exactly one synchronized edge. For the clear-versus-edge collision, the bench times its write to the edge-detect cycle by counting the two synchronizer stages.

// File: rtl/odio_pkg.sv
package odio_pkg;
  localparam int REG_AW = 5;

  // word index = byte address [4:2]
  localparam logic [2:0] WI_OUT   = 3'd0;
  localparam logic [2:0] WI_LVL   = 3'd1;
  localparam logic [2:0] WI_RISE  = 3'd2;
  localparam logic [2:0] WI_FALL  = 3'd3;
  localparam logic [2:0] WI_PEND  = 3'd4;
  localparam logic [2:0] WI_CTRL  = 3'd5;

  localparam int CTL_IE = 0;
  localparam int CTL_PP = 1;
endpackage

// File: rtl/odio_sync.sv
module odio_sync #(
  parameter int W = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/odio_edge_pend.sv
module odio_edge_pend #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] hit;

  always_comb hit = (lvl & ~lvl_d & rise_sel) | (~lvl & lvl_d & fall_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= '1;
      pend  <= '0;
    end else begin
      lvl_d <= lvl;
      pend  <= (pend & ~clr) | hit;
    end
  end

  // R5/R6: a flag only drops where a clear was requested
  a_r5_hold_unless_cleared: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));
  // R4: a new flag needs one of its masks set
  a_r4_new_flag_masked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend & ~$past(pend)) & ~$past(rise_sel | fall_sel)) == '0));
endmodule

// File: rtl/odio_drive.sv
module odio_drive #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_pull,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] oe,
  output logic [W-1:0] o
);
  logic [W-1:0] armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= '0;
    else if (push_pull) armed_q <= armed_q | wr_bits;
  end

  always_comb begin
    if (push_pull) begin
      oe = armed_q;
      o  = latch;
    end else begin
      oe = ~latch;
      o  = '0;
    end
  end

  // R8: driver enables are sticky until reset
  a_r8_sticky_enable: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(armed_q) & ~armed_q) == '0));
  // R2: open-drain mode never drives a high level
  a_r2_no_active_high: assert property (@(posedge clk) disable iff (rst)
    !push_pull |-> (o == '0));
endmodule

// File: rtl/odio_port.sv
module odio_port
  import odio_pkg::*;
#(
  parameter int W  = 24,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW/8-1:0]   reg_wstrb,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [W-1:0]      line_in,
  output logic [W-1:0]      line_oe,
  output logic [W-1:0]      line_o,
  output logic              irq
);
  localparam int PADW = DW - W;

  logic [W-1:0] bmask;
  logic [W-1:0] out_q, rise_q, fall_q;
  logic [1:0]   ctrl_q;
  logic [W-1:0] lvl, pend, clr;
  logic [2:0]   widx;
  logic         wr_out, wr_rise, wr_fall, wr_pend, wr_ctrl;

  for (genvar i = 0; i < W; i++) begin : g_bmask
    assign bmask[i] = reg_wstrb[i/8];
  end

  assign widx    = reg_addr[4:2];
  assign wr_out  = reg_we && (widx == WI_OUT);
  assign wr_rise = reg_we && (widx == WI_RISE);
  assign wr_fall = reg_we && (widx == WI_FALL);
  assign wr_pend = reg_we && (widx == WI_PEND);
  assign wr_ctrl = reg_we && (widx == WI_CTRL);
  assign clr     = wr_pend ? (reg_wdata[W-1:0] & bmask) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '1;
      rise_q <= '0;
      fall_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_out)  out_q  <= (out_q  & ~bmask) | (reg_wdata[W-1:0] & bmask);
      if (wr_rise) rise_q <= (rise_q & ~bmask) | (reg_wdata[W-1:0] & bmask);
      if (wr_fall) fall_q <= (fall_q & ~bmask) | (reg_wdata[W-1:0] & bmask);
      if (wr_ctrl && reg_wstrb[0]) ctrl_q <= reg_wdata[1:0];
    end
  end

  odio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(line_in), .dout(lvl)
  );

  odio_edge_pend #(.W(W)) u_pend (
    .clk(clk), .rst(rst), .lvl(lvl), .rise_sel(rise_q), .fall_sel(fall_q),
    .clr(clr), .pend(pend)
  );

  odio_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .push_pull(ctrl_q[CTL_PP]), .latch(out_q),
    .wr_bits(wr_out ? bmask : '0), .oe(line_oe), .o(line_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ctrl_q[CTL_IE] && (|pend);
      case (widx)
        WI_OUT:  reg_rdata <= {{PADW{1'b0}}, out_q};
        WI_LVL:  reg_rdata <= {{PADW{1'b0}}, lvl};
        WI_RISE: reg_rdata <= {{PADW{1'b0}}, rise_q};
        WI_FALL: reg_rdata <= {{PADW{1'b0}}, fall_q};
        WI_PEND: reg_rdata <= {{PADW{1'b0}}, pend};
        WI_CTRL: reg_rdata <= {{(DW-2){1'b0}}, ctrl_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7: enable off means no request on the next cycle
  a_r7_gate_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CTL_IE] |=> !irq);
  // R7: enable on with pending bits raises the request
  a_r7_request: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_IE] && (pend != '0)) |=> irq);
endmodule

// File: tb/odio_port_bench.sv
module odio_port_bench;
  localparam int W = 24;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_wstrb = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [W-1:0] ext = '1;
  logic [W-1:0] line_in, line_oe, line_o;
  logic        irq;
  int errs = 0, checks = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  // pad model: a driven line takes the driven value, else the external level
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign line_in[i] = line_oe[i] ? line_o[i] : ext[i];
  end

  odio_port u_odio_port (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wstrb(reg_wstrb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_in(line_in), .line_oe(line_oe), .line_o(line_o), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wstrb = s; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wstrb = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(5'h00, d); chk("R1 out latch", d, 32'h00FF_FFFF);
    rd(5'h08, d); chk("R1 rise mask", d, 0);
    rd(5'h0C, d); chk("R1 fall mask", d, 0);
    rd(5'h10, d); chk("R1 pending", d, 0);
    rd(5'h14, d); chk("R1 control", d, 0);
    chk("R1 line_oe", {8'h0, line_oe}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_open_drain();
    logic [31:0] d;
    ext = '1;
    wr(5'h00, 32'h00FF_FFFE, 4'hF);
    chk("R2 oe bit0", {8'h0, line_oe}, 32'h1);
    chk("R2 o bit0", {8'h0, line_o}, 0);
    settle();
    rd(5'h04, d); chk("R2 pulled low", d, 32'h00FF_FFFE);
    wr(5'h00, 32'h00FF_FFFF, 4'hF);
    chk("R2 release", {8'h0, line_oe}, 0);
    ext = 24'hA5_3C0F;
    settle();
    rd(5'h04, d); chk("R3 external level", d, 32'h00A5_3C0F);
    wr(5'h04, 32'h0, 4'hF);
    rd(5'h04, d); chk("R10 level write ignored", d, 32'h00A5_3C0F);
    ext = '1;
    settle();
  endtask

  task automatic t_masks();
    logic [31:0] d;
    wr(5'h08, 32'h5, 4'hF);
    wr(5'h0C, 32'h6, 4'hF);
    wr(5'h10, 32'hFFFFFF, 4'hF);
    ext = 24'hFF_FFF0;
    settle();
    rd(5'h10, d); chk("R4 falling step", d, 32'h6);
    wr(5'h10, 32'h2, 4'hF);
    rd(5'h10, d); chk("R5 clear one bit", d, 32'h4);
    wr(5'h10, 32'h0, 4'hF);
    rd(5'h10, d); chk("R5 zero write keeps", d, 32'h4);
    wr(5'h10, 32'h4, 4'hF);
    ext = '1;
    settle();
    rd(5'h10, d); chk("R4 rising step", d, 32'h5);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R7 gated off", {31'h0, irq}, 0);
    wr(5'h14, 32'h1, 4'h1);
    @(negedge clk);
    chk("R7 raised", {31'h0, irq}, 1);
    wr(5'h10, 32'hFF, 4'hF);
    @(negedge clk);
    chk("R7 dropped after clear", {31'h0, irq}, 0);
    rd(5'h10, d); chk("R5 all clear", d, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    // bit 2 flags both edges; first get it pending
    ext[2] = 1'b0;
    settle();
    rd(5'h10, d); chk("R6 setup pending", d, 32'h4);
    @(negedge clk);
    ext[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 5'h10; reg_wdata = 32'h4; reg_wstrb = 4'hF; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(5'h10, d); chk("R6 edge beats clear", d, 32'h4);
    wr(5'h10, 32'h4, 4'hF);
    rd(5'h10, d); chk("R6 later clear works", d, 0);
    wr(5'h14, 32'h0, 4'h1);
  endtask

  task automatic t_push_pull();
    logic [31:0] d;
    do_reset();
    wr(5'h14, 32'h2, 4'h1);
    chk("R8 none armed", {8'h0, line_oe}, 0);
    wr(5'h00, 32'h0012_34A5, 4'h1);
    chk("R8 byte0 armed", {8'h0, line_oe}, 32'h0000_00FF);
    chk("R8 drives latch", {8'h0, line_o}, 32'h00FF_FFA5);
    rd(5'h00, d); chk("R9 strobe keeps bytes", d, 32'h00FF_FFA5);
    wr(5'h00, 32'h0000_5A00, 4'h2);
    chk("R8 byte1 armed", {8'h0, line_oe}, 32'h0000_FFFF);
    wr(5'h00, 32'h0000_00FF, 4'h1);
    chk("R8 stays armed", {8'h0, line_oe}, 32'h0000_FFFF);
    chk("R8 follows latch", {8'h0, line_o}, 32'h00FF_5AFF);
  endtask

  initial begin
    t_reset();
    t_open_drain();
    t_masks();
    t_irq();
    t_collision();
    t_push_pull();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule